// File: doc/BRIEF.md
# Multi-Channel Gray Capture and Readout

This block sits behind a bank of ramp comparators in a multi-channel ramp-compare converter. A Gray-coded conversion count is shared by all channels. Each channel has a digital fire input from its comparator. The first time a channel fires, the channel freezes the count value present at that clock edge. A channel that never fires before the count stops keeps the final count, which is the full-scale code.

A load pulse copies every channel's frozen value into a second bank of readout registers in one cycle. The capture side can then be re-armed with the debounce clear and run a fresh conversion while the previous results are read out. Readout goes one channel at a time. A 3-bit address picks one readout register. Only that register passes through the Gray-to-binary decoder. The decoded word drives a shared tri-state data bus while output enable is high.

Top module: `adc_capture_readout`

## Requirements
- R1: On the first clock edge at which a channel's fire input is high while armed, the channel captures the Gray count present at that edge, where Gray = binary ^ (binary >> 1).
- R2: Once a channel has captured, further changes of its fire input, and further changes of the count, leave its captured value unchanged until the debounce clear.
- R3: A clock edge with the debounce clear high re-arms every channel, so that the next fire captures a new count.
- R4: A channel that is armed and never fires follows the count, so it holds the final count value (full scale) once the count stops.
- R5: A clock edge with load high copies every channel's captured value into its readout register. Readout registers hold between loads, while capture proceeds.
- R6: The 3-bit address selects the readout register of channel number addr_i (0 to 7) for the data bus.
- R7: The bus word is the binary decode of the selected register, with b[W-1] = g[W-1] and b[i] = b[i+1] ^ g[i]. It is combinational on the address.
- R8: With output enable low the data bus is released to high impedance (drive_o low). With output enable high the bus is driven (drive_o high).
- R9: After the active-low asynchronous reset, all captured and readout values are zero and all channels are armed.
- R10: When the debounce clear and a fire are high at the same edge, the clear wins and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_gray_i | input | 12 | Shared Gray-coded conversion count |
| fire_i | input | 8 | Per-channel comparator fire, bit n is channel n |
| db_clr_i | input | 1 | Debounce clear, re-arms all channels |
| load_i | input | 1 | Copy captured values to readout registers |
| addr_i | input | 3 | Readout channel select |
| oe_i | input | 1 | Output enable for the data bus |
| data_io | inout | 12 | Tri-state binary data bus |
| drive_o | output | 1 | High while the data bus is driven |

## Verification
A wrong armed flag or a wrong capture register shows up as a bus word that differs from the bench's fire-cycle index. This is seen at the readout after the next load, one cycle after the load edge. A readout register that fails to hold is caught immediately: the bench reads the old results before loading, after a full new conversion has run. A decode or select fault corrupts the bus word in the same cycle that the address changes.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned DEF_CH = 8;
  localparam int unsigned DEF_W  = 12;
endpackage

// File: rtl/adc_rd_g2b.sv
module adc_rd_g2b #(
  parameter int unsigned W = adc_rd_pkg::DEF_W
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  assign bin_o[W-1] = gray_i[W-1];
  for (genvar i = 0; i < W-1; i++) begin : g_bit
    assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
  end

  always_comb begin
    AST_DECODE_INV: assert ((bin_o ^ (bin_o >> 1)) == gray_i) // R7
      else $error("gray decode mismatch");
  end
endmodule

// File: rtl/adc_rd_chan.sv
module adc_rd_chan #(
  parameter int unsigned W = adc_rd_pkg::DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         fire_i,
  input  logic         db_clr_i,
  input  logic         load_i,
  output logic [W-1:0] out_o
);
  logic         fired_q;
  logic [W-1:0] cap_q;
  logic [W-1:0] out_q;

  // armed channel tracks the count; first fire freezes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      cap_q   <= '0;
    end else if (db_clr_i) begin
      fired_q <= 1'b0;
      cap_q   <= cnt_i;
    end else if (!fired_q) begin
      fired_q <= fire_i;
      cap_q   <= cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= '0;
    else if (load_i) out_q <= cap_q;
  end

  assign out_o = out_q;

  AST_FIRE_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!db_clr_i && fire_i) |=> fired_q) // R1
    else $error("fire not latched");
  AST_HOLD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !db_clr_i) |=> ($stable(cap_q) && fired_q)) // R2
    else $error("capture not held");
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_clr_i |=> !fired_q) // R10
    else $error("clear lost to fire");
  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (out_q == $past(cap_q))) // R5
    else $error("load copy wrong");
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(out_q)) // R5
    else $error("readout changed without load");
endmodule

// File: rtl/adc_capture_readout.sv
module adc_capture_readout #(
  parameter int unsigned N_CH = adc_rd_pkg::DEF_CH,
  parameter int unsigned W    = adc_rd_pkg::DEF_W,
  localparam int unsigned AW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    cnt_gray_i,
  input  logic [N_CH-1:0] fire_i,
  input  logic            db_clr_i,
  input  logic            load_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            oe_i,
  inout  wire  [W-1:0]    data_io,
  output logic            drive_o
);
  logic [W-1:0] ch_out [N_CH];
  logic [W-1:0] sel_gray;
  logic [W-1:0] sel_bin;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    adc_rd_chan #(.W(W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_i    (cnt_gray_i),
      .fire_i   (fire_i[c]),
      .db_clr_i (db_clr_i),
      .load_i   (load_i),
      .out_o    (ch_out[c])
    );
  end

  assign sel_gray = ch_out[addr_i];

  adc_rd_g2b #(.W(W)) u_g2b (
    .gray_i (sel_gray),
    .bin_o  (sel_bin)
  );

  assign data_io = oe_i ? sel_bin : {W{1'bz}};
  assign drive_o = oe_i;

  AST_SEL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(addr_i) -> $stable(sel_bin))) // R6
    else $error("selected word moved");
endmodule

// File: tb/sim_adc_capture_readout.sv
module sim_adc_capture_readout;
  localparam int W = 12;
  localparam int NC = 8;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cnt_gray = '0;
  logic [NC-1:0] fire = '0;
  logic db_clr = 1'b0, load = 1'b0, oe = 1'b0;
  logic [2:0] addr = '0;
  wire  [W-1:0] bus;
  logic drive;

  int n_chk = 0, n_bad = 0;
  int prev_exp [NC];

  always #2 clk = ~clk;

  adc_capture_readout u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_gray_i(cnt_gray), .fire_i(fire),
    .db_clr_i(db_clr), .load_i(load), .addr_i(addr), .oe_i(oe),
    .data_io(bus), .drive_o(drive)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expv(input int fa, input int clr_until);
    if (fa > FULL) return FULL;
    return (fa < clr_until) ? clr_until : fa;
  endfunction

  // Count from 0 to full scale, then hold; fire[c] rises at fa[c]
  task automatic run_ramp(input int fa [NC], input int clr_until, input bit glitch);
    for (int n = 0; n <= FULL + 3; n++) begin
      @(negedge clk);
      cnt_gray = W'((n > FULL ? FULL : n) ^ ((n > FULL ? FULL : n) >> 1));
      db_clr = (n < clr_until);
      for (int c = 0; c < NC; c++) begin
        if (glitch) fire[c] = (n >= fa[c] && n < fa[c] + 3) || (n >= fa[c] + 50);
        else        fire[c] = (n >= fa[c]);
      end
    end
    @(negedge clk);
    db_clr = 1'b0;
    fire = '0;
  endtask

  task automatic do_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic read_all(input string req, input int exp [NC]);
    oe = 1'b1;
    for (int c = 0; c < NC; c++) begin
      addr = 3'(c);
      #1;
      chk(req, int'(bus), exp[c]);
      chk("R8 driven", int'(drive), 1);
    end
    oe = 1'b0;
    #1;
    chk("R8 high-z", int'(drive), 0);
  endtask

  task automatic t_reset();
    int z [NC];
    foreach (z[i]) z[i] = 0;
    read_all("R9 reset zero", z);
  endtask

  task automatic t_basic();
    int fa [NC] = '{0, 1, 2, 2047, 2048, 4094, 1365, 5000};
    int e [NC];
    run_ramp(fa, 0, 1'b0);
    do_load();
    foreach (e[i]) e[i] = expv(fa[i], 0);
    read_all("R1/R4/R6/R7 basic", e);
    prev_exp = e;
  endtask

  task automatic t_glitch_dbuf();
    int fa [NC] = '{10, 100, 700, 3000, 4000, 3, 9, 2730};
    int e [NC];
    run_ramp(fa, 1, 1'b1);                 // R3 re-arm at first edge
    read_all("R5 readout held during capture", prev_exp);
    do_load();
    foreach (e[i]) e[i] = expv(fa[i], 1);
    read_all("R2/R3 first fire kept", e);
    prev_exp = e;
  endtask

  task automatic t_no_clear();
    int fa [NC] = '{50, 50, 50, 50, 50, 50, 50, 50};
    run_ramp(fa, 0, 1'b0);
    do_load();
    read_all("R2 no recapture without clear", prev_exp);
  endtask

  task automatic t_clr_priority();
    int fa [NC] = '{0, 150, 199, 200, 201, 4095, 5000, 300};
    int e [NC];
    run_ramp(fa, 200, 1'b0);
    do_load();
    foreach (e[i]) e[i] = expv(fa[i], 200);
    read_all("R10/R3/R4 clear priority", e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_glitch_dbuf();
    t_no_clear();
    t_clr_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule